// File: doc/BRIEF.md
# Key-Locked DRAM Controller Configuration Register Bank

This block is the software-visible register space of a DRAM controller, reduced to the registers and write rules that boot firmware depends on. A simple request bus carries 32-bit reads and writes into a 4 KiB window. Word 0 is a protection register. Writing the exact unlock word 0xFC600309 there opens the bank. Writing any other value closes it again. While the bank is closed, writes to every other word are discarded.

Word 1 holds the configuration. Part of it is fixed when the block is elaborated: a silicon variant and a DRAM size are encoded there, and software cannot change those fields. In the second variant, a PHY status word always reports not busy and an ECC self-test word always reports finished and passed, whatever software writes to them.

Every request gets a response one cycle later. Partial-word or misaligned requests get an error response instead. Reads outside the implemented words return zero.

Top module: `memctl_keyed_regfile`

## Requirements
- R1: After reset every word reads zero, except the configuration word (byte offset 0x04), which reads its fixed pattern. The protection word reads 0, so the bank starts locked.
- R2: A word write to offset 0x00 stores 1 when the data equals 0xFC600309 and 0 for any other value. This applies whether the bank is locked or not.
- R3: While the protection word holds 0, a write to any offset other than 0x00 leaves every word unchanged.
- R4: For variant 0, a configuration write stores (data AND NOT 0xFFFFF84C) OR fixed. The fixed value is 0x40 OR the size code.
- R5: For variant 1, a configuration write stores (data AND NOT 0xF00FC04C) OR fixed. The fixed value is 0x1008000C OR the size code.
- R6: The size code sits in bits 1:0. For variant 0, 64/128/256/512 MiB encode as 0/1/2/3. For variant 1, 128/256/512/1024 MiB encode as 0/1/2/3. Any other size gives code 2 for either variant.
- R7: For variant 1, a write to offset 0x60 stores the data with bit 0 cleared. For variant 0, the data is stored unchanged.
- R8: For variant 1, a write to offset 0x70 stores the data with bit 12 set and bit 13 cleared. For variant 0, the data is stored unchanged.
- R9: Each request raises rspValid for exactly the following cycle. On a read, rspRdata then carries the word stored at the time of the request.
- R10: An access at or beyond NUM_WORDS*4 bytes reads zero. A write there changes no word, including words whose low index bits match.
- R11: A request with reqSize other than word (2'b10), or with address bits 1:0 nonzero, returns rspErr=1 with rspRdata=0 and changes no word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request present this cycle |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | 12 | Byte address in the 4 KiB window |
| reqSize | input | 2 | Access size: 00 byte, 01 half, 10 word, 11 reserved |
| reqWdata | input | 32 | Write data |
| rspValid | output | 1 | Response present (one cycle after request) |
| rspErr | output | 1 | Request rejected as not a full aligned word |
| rspRdata | output | 32 | Read data; zero for writes, errors and out-of-range reads |

## Verification
A wrong lock bit shows up on the next read of any word: writes that should have been dropped come back, or writes that should have landed are missing. That is why the bench reads back the whole implemented array after every phase of locked, unlocked, out-of-range and malformed writes. A shaping fault in the configuration, PHY or test word appears on the read that follows the write. An index or decode fault shows up as aliasing when the full array is read back after out-of-range writes. Response timing errors show on the very next cycle, because every transfer checks rspValid and rspErr.

// File: rtl/memctl_regs_pkg.sv
package memctl_regs_pkg;

  localparam logic [31:0] UNLOCK_WORD = 32'hFC60_0309;

  // Word indices whose write behaviour is special
  localparam int KEY_IDX  = 0;
  localparam int CFG_IDX  = 1;
  localparam int PHY_IDX  = 24;  // byte offset 0x60
  localparam int TEST_IDX = 28;  // byte offset 0x70

  localparam logic [31:0] PHY_BUSY_BIT  = 32'h0000_0001;
  localparam logic [31:0] TEST_DONE_BIT = 32'h0000_1000;
  localparam logic [31:0] TEST_FAIL_BIT = 32'h0000_2000;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_HALF = 2'b01,
    SZ_WORD = 2'b10,
    SZ_RSVD = 2'b11
  } accSize_e;

  typedef enum logic [2:0] {
    WK_NONE,
    WK_KEY,
    WK_CFG,
    WK_PHY,
    WK_TEST,
    WK_PLAIN
  } wrKind_e;

  typedef struct packed {
    logic    rspFire;
    logic    rdFire;
    logic    errFire;
    wrKind_e wrKind;
  } ctrlStrobe_t;

  function automatic logic [1:0] sizeCode(input int variant, input int mib);
    if (variant == 0) begin
      case (mib)
        64:      return 2'd0;
        128:     return 2'd1;
        256:     return 2'd2;
        512:     return 2'd3;
        default: return 2'd2;
      endcase
    end else begin
      case (mib)
        128:     return 2'd0;
        256:     return 2'd1;
        512:     return 2'd2;
        1024:    return 2'd3;
        default: return 2'd2;
      endcase
    end
  endfunction

  function automatic logic [31:0] roMask(input int variant);
    if (variant == 0) return 32'hFFFF_F800 | 32'h0000_0040 | 32'h0000_000C;
    else              return 32'hF000_0000 | 32'h0008_0000 | 32'h0007_C000
                           | 32'h0000_0040 | 32'h0000_000C;
  endfunction

  function automatic logic [31:0] fixedCfg(input int variant, input int mib);
    logic [31:0] v;
    if (variant == 0) v = 32'h0000_0040;
    else              v = 32'h1000_0000 | 32'h0008_0000 | 32'h0000_000C;
    v[1:0] = sizeCode(variant, mib);
    return v;
  endfunction

endpackage

// File: rtl/memctl_regs_ctrl.sv
module memctl_regs_ctrl
  import memctl_regs_pkg::*;
#(
  parameter int VARIANT   = 1,
  parameter int NUM_WORDS = 1024,
  parameter int ADDR_W    = 12,
  localparam int IDX_W    = ADDR_W - 2
) (
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [1:0]        reqSize,
  input  logic              unlocked,
  output ctrlStrobe_t       st,
  output logic [IDX_W-1:0]  idx,
  output logic              inRange
);

  logic okShape;
  logic wrOk;
  logic isKey;
  logic isCfg;
  logic isPhy;
  logic isTest;

  assign idx     = reqAddr[ADDR_W-1:2];
  assign okShape = (reqSize == SZ_WORD) && (reqAddr[1:0] == 2'b00);

  generate
    if (NUM_WORDS >= (1 << IDX_W)) begin : g_full
      assign inRange = 1'b1;
    end else begin : g_part
      assign inRange = (idx < IDX_W'(NUM_WORDS));
    end
  endgenerate

  assign isKey = (idx == IDX_W'(KEY_IDX));
  assign isCfg = (idx == IDX_W'(CFG_IDX));

  generate
    if (VARIANT == 1) begin : g_status_fix
      assign isPhy  = (idx == IDX_W'(PHY_IDX));
      assign isTest = (idx == IDX_W'(TEST_IDX));
    end else begin : g_status_plain
      assign isPhy  = 1'b0;
      assign isTest = 1'b0;
    end
  endgenerate

  assign wrOk = reqValid && reqWrite && okShape && inRange;

  always_comb begin
    st.rspFire = reqValid;
    st.errFire = reqValid && !okShape;
    st.rdFire  = reqValid && !reqWrite && okShape;
    st.wrKind  = WK_NONE;
    if (wrOk) begin
      if (isKey)                 st.wrKind = WK_KEY;
      else if (!unlocked)        st.wrKind = WK_NONE;
      else if (isCfg)            st.wrKind = WK_CFG;
      else if (isPhy)            st.wrKind = WK_PHY;
      else if (isTest)           st.wrKind = WK_TEST;
      else                       st.wrKind = WK_PLAIN;
    end
  end

endmodule

// File: rtl/memctl_regs_dp.sv
module memctl_regs_dp
  import memctl_regs_pkg::*;
#(
  parameter int VARIANT   = 1,
  parameter int DRAM_MIB  = 512,
  parameter int NUM_WORDS = 1024,
  parameter int IDX_W     = 10,
  localparam int MW       = $clog2(NUM_WORDS),
  localparam logic [31:0] RO_MASK = roMask(VARIANT),
  localparam logic [31:0] FIXED   = fixedCfg(VARIANT, DRAM_MIB)
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctrlStrobe_t      st,
  input  logic [IDX_W-1:0] idx,
  input  logic             inRange,
  input  logic [31:0]      wdata,
  output logic             unlocked,
  output logic             rspValid,
  output logic             rspErr,
  output logic [31:0]      rspRdata
);

  logic [31:0]   mem [NUM_WORDS];
  logic [31:0]   nextWord;
  logic [MW-1:0] memIdx;

  assign memIdx   = idx[MW-1:0];
  assign unlocked = mem[KEY_IDX][0];

  always_comb begin
    case (st.wrKind)
      WK_KEY:  nextWord = (wdata == UNLOCK_WORD) ? 32'd1 : 32'd0;
      WK_CFG:  nextWord = (wdata & ~RO_MASK) | FIXED;
      WK_PHY:  nextWord = wdata & ~PHY_BUSY_BIT;
      WK_TEST: nextWord = (wdata | TEST_DONE_BIT) & ~TEST_FAIL_BIT;
      default: nextWord = wdata;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_WORDS; i++) begin
        mem[i] <= (i == CFG_IDX) ? FIXED : 32'd0;
      end
    end else if (st.wrKind != WK_NONE) begin
      mem[memIdx] <= nextWord;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rspValid <= 1'b0;
      rspErr   <= 1'b0;
      rspRdata <= '0;
    end else begin
      rspValid <= st.rspFire;
      rspErr   <= st.errFire;
      rspRdata <= (st.rdFire && inRange) ? mem[memIdx] : 32'd0;
    end
  end

  // The protection word only ever holds 0 or 1
  p_key_binary_r2: assert property (@(posedge clk) disable iff (!rstN)
    mem[KEY_IDX][31:1] == 31'd0);

  // The read-only configuration fields always match the fixed pattern
  p_cfg_fixed_r4_r5: assert property (@(posedge clk) disable iff (!rstN)
    (mem[CFG_IDX] & RO_MASK) == (FIXED & RO_MASK));

  // While locked, only a key write may change the bank
  p_locked_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
    (!unlocked && st.wrKind != WK_KEY) |=> $stable(mem[CFG_IDX]));

  generate
    if (VARIANT == 1) begin : g_status_chk
      p_phy_idle_r7: assert property (@(posedge clk) disable iff (!rstN)
        (st.wrKind == WK_PHY) |=> !mem[PHY_IDX][0]);
      p_test_pass_r8: assert property (@(posedge clk) disable iff (!rstN)
        (st.wrKind == WK_TEST) |=> (mem[TEST_IDX][12] && !mem[TEST_IDX][13]));
    end
  endgenerate

endmodule

// File: rtl/memctl_keyed_regfile.sv
module memctl_keyed_regfile
  import memctl_regs_pkg::*;
#(
  parameter int VARIANT   = 1,
  parameter int DRAM_MIB  = 512,
  parameter int NUM_WORDS = 1024,
  localparam int ADDR_W   = 12,
  localparam int IDX_W    = ADDR_W - 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [1:0]        reqSize,
  input  logic [31:0]       reqWdata,
  output logic              rspValid,
  output logic              rspErr,
  output logic [31:0]       rspRdata
);

  ctrlStrobe_t      st;
  logic [IDX_W-1:0] idx;
  logic             inRange;
  logic             unlocked;

  memctl_regs_ctrl #(
    .VARIANT  (VARIANT),
    .NUM_WORDS(NUM_WORDS),
    .ADDR_W   (ADDR_W)
  ) u_ctrl (
    .reqValid(reqValid),
    .reqWrite(reqWrite),
    .reqAddr (reqAddr),
    .reqSize (reqSize),
    .unlocked(unlocked),
    .st      (st),
    .idx     (idx),
    .inRange (inRange)
  );

  memctl_regs_dp #(
    .VARIANT  (VARIANT),
    .DRAM_MIB (DRAM_MIB),
    .NUM_WORDS(NUM_WORDS),
    .IDX_W    (IDX_W)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .st      (st),
    .idx     (idx),
    .inRange (inRange),
    .wdata   (reqWdata),
    .unlocked(unlocked),
    .rspValid(rspValid),
    .rspErr  (rspErr),
    .rspRdata(rspRdata)
  );

  p_rsp_next_r9: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> rspValid);

  p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> !rspValid);

  p_bad_shape_err_r11: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && (reqSize != SZ_WORD || reqAddr[1:0] != 2'b00))
      |=> (rspErr && rspRdata == 32'd0));

  p_oob_zero_r10: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !reqWrite && (32'(reqAddr) >= 32'(NUM_WORDS) * 4))
      |=> (rspRdata == 32'd0));

endmodule

// File: tb/memctl_keyed_regfile_tb.sv
module memctl_keyed_regfile_tb;

  localparam int NW = 64;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqWrite = 1'b0;
  logic [11:0] reqAddr = '0;
  logic [1:0]  reqSize = 2'b10;
  logic [31:0] reqWdata = '0;

  logic        vB, eB, vA, eA, vC, eC, vD, eD;
  logic [31:0] dB, dA, dC, dD;

  int nChecks = 0;
  int nFails  = 0;

  logic [31:0] mA [NW];
  logic [31:0] mB [NW];

  always #5 clk = ~clk;

  // Variant 1, 1024 MiB
  memctl_keyed_regfile #(.VARIANT(1), .DRAM_MIB(1024), .NUM_WORDS(NW)) u_dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .reqSize(reqSize), .reqWdata(reqWdata),
    .rspValid(vB), .rspErr(eB), .rspRdata(dB));
  // Variant 0, unsupported 100 MiB
  memctl_keyed_regfile #(.VARIANT(0), .DRAM_MIB(100), .NUM_WORDS(NW)) u_dutA (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .reqSize(reqSize), .reqWdata(reqWdata),
    .rspValid(vA), .rspErr(eA), .rspRdata(dA));
  // Variant 1, unsupported 64 MiB
  memctl_keyed_regfile #(.VARIANT(1), .DRAM_MIB(64), .NUM_WORDS(NW)) u_dutC (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .reqSize(reqSize), .reqWdata(reqWdata),
    .rspValid(vC), .rspErr(eC), .rspRdata(dC));
  // Variant 0, 64 MiB
  memctl_keyed_regfile #(.VARIANT(0), .DRAM_MIB(64), .NUM_WORDS(NW)) u_dutD (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .reqSize(reqSize), .reqWdata(reqWdata),
    .rspValid(vD), .rspErr(eD), .rspRdata(dD));

  task automatic check(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s %s: actual %08h expected %08h", tag, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("  %0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  endtask

  // One request; outputs sampled at the following falling edge
  task automatic xfer(input logic wr, input logic [11:0] a, input logic [1:0] sz,
                      input logic [31:0] d);
    @(negedge clk);
    reqValid = 1'b1; reqWrite = wr; reqAddr = a; reqSize = sz; reqWdata = d;
    @(negedge clk);
    reqValid = 1'b0;
  endtask

  function automatic logic badShape(input logic [11:0] a, input logic [1:0] sz);
    return (sz != 2'b10) || (a[1:0] != 2'b00);
  endfunction

  task automatic mdlWrite(input logic [11:0] a, input logic [1:0] sz, input logic [31:0] d);
    int i;
    if (badShape(a, sz)) return;
    if (a >= 12'(NW * 4)) return;
    i = int'(a[7:2]);
    if (i == 0) begin
      mB[0] = (d == 32'hFC60_0309) ? 32'd1 : 32'd0;
      mA[0] = mB[0];
      return;
    end
    if (mB[0] == 32'd0) return;
    if (i == 1) begin
      mA[1] = (d & ~32'hFFFF_F84C) | 32'h0000_0042;
      mB[1] = (d & ~32'hF00F_C04C) | 32'h1008_000F;
    end else if (i == 24) begin
      mA[i] = d;
      mB[i] = d & ~32'h1;
    end else if (i == 28) begin
      mA[i] = d;
      mB[i] = (d | 32'h1000) & ~32'h2000;
    end else begin
      mA[i] = d;
      mB[i] = d;
    end
  endtask

  task automatic wr(input string tag, input logic [11:0] a, input logic [1:0] sz,
                    input logic [31:0] d);
    xfer(1'b1, a, sz, d);
    mdlWrite(a, sz, d);
    check(tag, "write rspValid", 32'(vB), 32'd1);
    check(tag, "write rspErr", 32'(eB), 32'(badShape(a, sz)));
    check(tag, "write rspErr A", 32'(eA), 32'(badShape(a, sz)));
  endtask

  task automatic rd(input string tag, input logic [11:0] a, input logic [1:0] sz);
    logic [31:0] expA, expB;
    xfer(1'b0, a, sz, 32'h0);
    if (badShape(a, sz) || a >= 12'(NW * 4)) begin
      expA = 32'd0; expB = 32'd0;
    end else begin
      expA = mA[a[7:2]]; expB = mB[a[7:2]];
    end
    check("R9", "read rspValid", 32'(vB), 32'd1);
    check(tag, "read rspErr", 32'(eB), 32'(badShape(a, sz)));
    check(tag, $sformatf("read B @%03h", a), dB, expB);
    check(tag, $sformatf("read A @%03h", a), dA, expA);
  endtask

  task automatic readAll(input string tag);
    for (int i = 0; i < NW; i++) rd(tag, 12'(i * 4), 2'b10);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nFails++;
    nChecks++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    for (int i = 0; i < NW; i++) begin mA[i] = 32'd0; mB[i] = 32'd0; end
    mA[1] = 32'h0000_0042;
    mB[1] = 32'h1008_000F;

    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1", "rspValid in reset", 32'(vB), 32'd0);
    rstN = 1'b1;
    @(negedge clk);
    check("R9", "idle rspValid", 32'(vB), 32'd0);

    // R1 reset image, R6 size codes and fallback
    readAll("R1");
    xfer(1'b0, 12'h004, 2'b10, 32'h0);
    check("R6", "variant1 fallback cfg", dC, 32'h1008_000E);
    check("R6", "variant0 64MiB cfg", dD, 32'h0000_0040);
    check("R6", "variant0 fallback cfg", dA, 32'h0000_0042);
    check("R6", "variant1 1024MiB cfg", dB, 32'h1008_000F);

    // R3 locked: every non-key write dropped
    for (int i = 1; i < NW; i++) wr("R3", 12'(i * 4), 2'b10, 32'hDEAD_BEEF ^ 32'(i));
    readAll("R3");

    // R2 near-miss keys keep the bank locked
    for (int k = 0; k < 32; k++) begin
      wr("R2", 12'h000, 2'b10, 32'hFC60_0309 ^ (32'd1 << k));
      rd("R2", 12'h000, 2'b10);
    end
    // R11 magic word with a partial size is rejected
    wr("R11", 12'h000, 2'b01, 32'hFC60_0309);
    rd("R11", 12'h000, 2'b10);
    wr("R2", 12'h000, 2'b10, 32'hFC60_0309);
    rd("R2", 12'h000, 2'b10);
    check("R2", "unlocked key value", dB, 32'd1);

    // Unlocked fill and readback
    for (int i = 2; i < NW; i++) wr("R9", 12'(i * 4), 2'b10, (32'(i) * 32'h0101_0101) ^ 32'hA5A5_A5A5);
    readAll("R9");

    // R4 / R5 configuration shaping with walking ones and extremes
    for (int b = 0; b < 32; b++) begin
      wr("R4", 12'h004, 2'b10, 32'd1 << b);
      rd("R4", 12'h004, 2'b10);
      rd("R5", 12'h004, 2'b10);
    end
    wr("R5", 12'h004, 2'b10, 32'hFFFF_FFFF);
    rd("R5", 12'h004, 2'b10);
    wr("R4", 12'h004, 2'b10, 32'h0);
    rd("R4", 12'h004, 2'b10);

    // R7 / R8 status and test words
    for (int p = 0; p < 4; p++) begin
      logic [31:0] pat;
      pat = (p == 0) ? 32'hFFFF_FFFF : (p == 1) ? 32'h0 : (p == 2) ? 32'h0000_2001 : 32'h5555_AAAA;
      wr("R7", 12'h060, 2'b10, pat);
      rd("R7", 12'h060, 2'b10);
      wr("R8", 12'h070, 2'b10, pat);
      rd("R8", 12'h070, 2'b10);
    end

    // R10 out-of-range accesses
    wr("R10", 12'h100, 2'b10, 32'h1234_5678);
    wr("R10", 12'h104, 2'b10, 32'hCAFE_0001);
    wr("R10", 12'hFFC, 2'b10, 32'h0BAD_F00D);
    wr("R10", 12'h800, 2'b10, 32'h0);
    rd("R10", 12'h100, 2'b10);
    rd("R10", 12'h104, 2'b10);
    rd("R10", 12'hFFC, 2'b10);
    readAll("R10");

    // R11 malformed accesses
    for (int s = 0; s < 4; s++) begin
      if (s != 2) begin
        wr("R11", 12'h014, 2'(s), 32'h7777_7777);
        rd("R11", 12'h014, 2'(s));
      end
    end
    for (int o = 1; o < 4; o++) begin
      wr("R11", 12'(32'h20 + o), 2'b10, 32'h3333_3333);
      rd("R11", 12'(32'h20 + o), 2'b10);
    end
    readAll("R11");

    // R3 relock with a wrong key, then writes dropped again
    wr("R3", 12'h000, 2'b10, 32'h0);
    for (int i = 1; i < NW; i++) wr("R3", 12'(i * 4), 2'b10, 32'hFFFF_0000 | 32'(i));
    readAll("R3");

    @(negedge clk);
    check("R9", "idle after traffic", 32'(vB), 32'd0);
    summary();
  end

endmodule